// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block steers a bus-master storage DMA through a table of memory segments. Software places 8-byte descriptors in memory, and each descriptor names a segment start address and a byte count. The block is given the table's base address. For each transfer command it reads descriptors through a single-beat 64-bit memory read port. It then sends the data mover one request per chunk, each with an address and a length, until the requested byte count is used up or the table runs out.

Segment state carries over from one transfer command to the next. A long disk command can therefore be served in several pieces, and each piece resumes inside the current segment. Two idle-time commands control the walk. One rewinds the table pointer to the base and keeps the segment state. The other starts a fresh table and also drops the segment state. The walk always stops when a descriptor flagged as last has been used up. It also stops once one fail-safe span of table bytes has been read, even if no flag has appeared. Every command ends with a one-cycle done pulse, the byte count and two status flags.

Top module: `sg_table_walker`

## Requirements
- R1: A descriptor fetch reads the address held in the table pointer. rd_data[31:0] is the segment address and rd_data[63:32] is the size word. The pointer starts at the base (with bits [1:0] forced to zero) and grows by 8 after every fetch.
- R2: The segment byte count is the size word with bit 0 and bits [30:16] cleared. A resulting count of zero means 65536 bytes.
- R3: Bit 31 of the size word (rd_data[63]) marks the final descriptor. Once that segment is used up, no further descriptor is read.
- R4: A descriptor is read only when the current segment has no bytes left. A partly used segment carries over into the next transfer command.
- R5: Each mover request is for min(remaining requested bytes, remaining segment bytes), starting at the segment's current address. After mv_ack, the address advances by that amount.
- R6: When the requested length is fully moved, done pulses for one cycle with underrun and cnt_err low, and xfer_cnt equals the requested length.
- R7: If the table ends before the request is met, done pulses with underrun high, and xfer_cnt holds the bytes actually moved.
- R8: When the segment is used up and the pointer is SPAN or more bytes past the base, walking stops as in R7 even if no final flag was seen.
- R9: tbl_rewind reloads the pointer from the base and keeps the segment state. tbl_load reloads the pointer and also empties the segment and clears the final flag.
- R10: If a chunk would take the total past CNT_LIMIT, that chunk is not issued. done then pulses with cnt_err high, underrun low, and xfer_cnt equal to CNT_LIMIT.
- R11: rd_req and mv_req each stay high, with stable address and length, until their ack. The two are never high together, and done lasts exactly one cycle.
- R12: A transfer command with req_len zero finishes with done, with no fetch and no mover request, and xfer_cnt is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base | input | AW | Descriptor table base address |
| tbl_load | input | 1 | Start a fresh table (accepted when idle) |
| tbl_rewind | input | 1 | Rewind pointer, keep segment state (accepted when idle) |
| go | input | 1 | Start a transfer command (accepted when idle) |
| req_len | input | CW | Bytes requested by the command |
| busy | output | 1 | A transfer command is in progress |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | AW | Descriptor address |
| rd_ack | input | 1 | Read complete, rd_data valid |
| rd_data | input | 64 | Descriptor, little-endian word pair |
| mv_req | output | 1 | Data mover request |
| mv_addr | output | AW | Chunk start address |
| mv_len | output | 17 | Chunk length in bytes |
| mv_ack | input | 1 | Chunk accepted |
| done | output | 1 | One-cycle end-of-command pulse |
| underrun | output | 1 | Table ended early (valid with done) |
| cnt_err | output | 1 | Byte count limit hit (valid with done) |
| xfer_cnt | output | CW | Bytes moved by the current or last command |

## Verification
A corrupted segment address or length becomes visible on the very next mover request, as a wrong mv_addr or mv_len. The bench therefore logs every chunk and compares it with the arithmetic expectation. A table pointer that is off by a step shows up on the next fetch, because the wrong descriptor is read and the chunks that follow point to the wrong segment. Lost or stale final-flag and page-span state shows up only at the end of a command, as a wrong underrun flag or wrong total. For that reason each scenario checks the flags and the fetch count together.

// File: rtl/sg_table_walker.sv
module sg_table_walker #(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int SPAN = 4096,
  parameter logic [CW-1:0] CNT_LIMIT = {1'b0, {(CW-1){1'b1}}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] tbl_base,
  input  logic          tbl_load,
  input  logic          tbl_rewind,
  input  logic          go,
  input  logic [CW-1:0] req_len,
  output logic          busy,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [63:0]   rd_data,
  output logic          mv_req,
  output logic [AW-1:0] mv_addr,
  output logic [16:0]   mv_len,
  input  logic          mv_ack,
  output logic          done,
  output logic          underrun,
  output logic          cnt_err,
  output logic [CW-1:0] xfer_cnt
);
  localparam int SW = 17;
  localparam logic [SW-1:0] FULL_SEG = SW'(1) << (SW - 1);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_FETCH, S_MOVE} state_t;

  state_t        state;
  logic [AW-1:0] base_q, ptr, seg_addr;
  logic [SW-1:0] seg_len, chunk, new_len;
  logic          seg_last;
  logic [CW-1:0] rem, cnt;
  logic [CW:0]   sum;
  logic          over, page_end;
  logic [AW-1:0] base_al;

  assign base_al  = {tbl_base[AW-1:2], 2'b00};
  assign chunk    = (rem < CW'(seg_len)) ? rem[SW-1:0] : seg_len;
  assign sum      = {1'b0, cnt} + (CW+1)'(chunk);
  assign over     = sum > {1'b0, CNT_LIMIT};
  assign page_end = (ptr - base_q) >= AW'(SPAN);
  assign new_len  = (rd_data[47:33] == '0) ? FULL_SEG : {1'b0, rd_data[47:33], 1'b0};

  assign busy     = state != S_IDLE;
  assign rd_req   = state == S_FETCH;
  assign rd_addr  = ptr;
  assign mv_req   = state == S_MOVE;
  assign mv_addr  = seg_addr;
  assign mv_len   = chunk;
  assign xfer_cnt = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      base_q   <= '0;
      ptr      <= '0;
      seg_addr <= '0;
      seg_len  <= '0;
      seg_last <= 1'b0;
      rem      <= '0;
      cnt      <= '0;
      done     <= 1'b0;
      underrun <= 1'b0;
      cnt_err  <= 1'b0;
    end else begin
      done     <= 1'b0;
      underrun <= 1'b0;
      cnt_err  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (tbl_load) begin
            base_q   <= base_al;
            ptr      <= base_al;
            seg_addr <= '0;
            seg_len  <= '0;
            seg_last <= 1'b0;
          end else if (tbl_rewind) begin
            base_q <= base_al;
            ptr    <= base_al;
          end else if (go) begin
            rem   <= req_len;
            cnt   <= '0;
            state <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (rem == '0) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (seg_len == '0) begin
            if (seg_last || page_end) begin
              done     <= 1'b1;
              underrun <= 1'b1;
              state    <= S_IDLE;
            end else begin
              state <= S_FETCH;
            end
          end else if (over) begin
            cnt     <= CNT_LIMIT;
            done    <= 1'b1;
            cnt_err <= 1'b1;
            state   <= S_IDLE;
          end else begin
            state <= S_MOVE;
          end
        end
        S_FETCH: begin
          if (rd_ack) begin
            seg_addr <= rd_data[AW-1:0];
            seg_len  <= new_len;
            seg_last <= rd_data[63];
            ptr      <= ptr + AW'(8);
            state    <= S_CHECK;
          end
        end
        S_MOVE: begin
          if (mv_ack) begin
            seg_addr <= seg_addr + AW'(chunk);
            seg_len  <= seg_len - chunk;
            rem      <= rem - CW'(chunk);
            cnt      <= sum[CW-1:0];
            state    <= S_CHECK;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_table_walker_chk.sv
module sg_table_walker_chk #(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int SPAN = 4096,
  parameter logic [CW-1:0] CNT_LIMIT = {1'b0, {(CW-1){1'b1}}}
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ack,
  input logic          mv_req,
  input logic [AW-1:0] mv_addr,
  input logic [16:0]   mv_len,
  input logic          mv_ack,
  input logic          done,
  input logic          underrun,
  input logic          cnt_err,
  input logic [CW-1:0] xfer_cnt,
  input logic [AW-1:0] base_q
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr)); // R11
  AST_MV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req && !mv_ack |=> mv_req && $stable(mv_addr) && $stable(mv_len)); // R11
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && mv_req)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_CHUNK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req |-> (mv_len != 17'd0) && (mv_len <= 17'h10000)); // R5
  AST_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr - base_q) < AW'(SPAN)); // R8
  AST_FLAG_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun || cnt_err) |-> done); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> xfer_cnt <= CNT_LIMIT); // R10
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(underrun && cnt_err)); // R10
endmodule

bind sg_table_walker sg_table_walker_chk #(
  .AW(AW), .CW(CW), .SPAN(SPAN), .CNT_LIMIT(CNT_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
  .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len), .mv_ack(mv_ack),
  .done(done), .underrun(underrun), .cnt_err(cnt_err), .xfer_cnt(xfer_cnt),
  .base_q(base_q)
);

// File: tb/sg_table_walker_bench.sv
`timescale 1ns/1ps
module sg_table_walker_bench;
  localparam logic [31:0] TBASE = 32'h0000_1000;
  localparam logic [31:0] LIMIT = 32'd100000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] tbl_base = TBASE;
  logic        tbl_load = 1'b0, tbl_rewind = 1'b0, go = 1'b0;
  logic [31:0] req_len = '0;
  logic        busy, rd_req, rd_ack = 1'b0, mv_req, mv_ack = 1'b0;
  logic [31:0] rd_addr, mv_addr, xfer_cnt;
  logic [63:0] rd_data = '0;
  logic [16:0] mv_len;
  logic        done, underrun, cnt_err;

  always #2.5 clk = ~clk;

  sg_table_walker #(.CNT_LIMIT(LIMIT)) u_sg_table_walker (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_load(tbl_load),
    .tbl_rewind(tbl_rewind), .go(go), .req_len(req_len), .busy(busy),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len), .mv_ack(mv_ack),
    .done(done), .underrun(underrun), .cnt_err(cnt_err), .xfer_cnt(xfer_cnt)
  );

  logic [63:0] tbl [64];
  int          rd_n = 0, mv_n = 0;
  logic [31:0] mv_a [1024];
  logic [16:0] mv_l [1024];
  longint      mv_sum = 0;
  int          tests = 0, fails = 0;

  function automatic logic [63:0] mem_rd(logic [31:0] a);
    logic [31:0] idx = (a - TBASE) >> 3;
    if (idx < 64) return tbl[idx];
    return {32'h0000_0003, a};
  endfunction

  always @(posedge clk) begin
    rd_ack <= rd_req && !rd_ack;
    rd_data <= mem_rd(rd_addr);
    mv_ack <= mv_req && !mv_ack;
    if (rd_req && rd_ack) rd_n <= rd_n + 1;
    if (mv_req && mv_ack) begin
      if (mv_n < 1024) begin
        mv_a[mv_n] <= mv_addr;
        mv_l[mv_n] <= mv_len;
      end
      mv_n   <= mv_n + 1;
      mv_sum <= mv_sum + longint'(mv_len);
    end
  end

  task automatic chk(string r, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  task automatic pulse_load(bit rewind);
    @(negedge clk);
    if (rewind) tbl_rewind = 1'b1; else tbl_load = 1'b1;
    @(negedge clk);
    tbl_rewind = 1'b0;
    tbl_load = 1'b0;
  endtask

  int m0, f0;
  logic r_und, r_err;
  logic [31:0] r_cnt;

  task automatic run(logic [31:0] len, string r);
    int wd = 0;
    m0 = mv_n;
    f0 = rd_n;
    @(negedge clk);
    req_len = len;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    while (!done && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL %s: watchdog, actual no done expected done", r);
    end
    r_und = underrun;
    r_err = cnt_err;
    r_cnt = xfer_cnt;
  endtask

  task automatic chk_move(int i, logic [31:0] a, logic [16:0] l, string r);
    chk(r, longint'(mv_a[m0+i]), longint'(a));
    chk(r, longint'(mv_l[m0+i]), longint'(l));
  endtask

  initial begin
    for (int i = 0; i < 64; i++) tbl[i] = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset rd_req", rd_req, 0);
    chk("R11 reset mv_req", mv_req, 0);
    chk("R11 reset done", done, 0);
    rst_n = 1'b1;

    pulse_load(0);
    run(32'd0, "R12");
    chk("R12 count", r_cnt, 0);
    chk("R12 no fetch", rd_n - f0, 0);
    chk("R12 no move", mv_n - m0, 0);
    chk("R12 no underrun", r_und, 0);

    tbl[0] = {32'h0000_0100, 32'h0000_8000};
    tbl[1] = {32'h8000_0080, 32'h0000_9000};
    pulse_load(0);
    run(32'h180, "R6");
    chk("R6 moves", mv_n - m0, 2);
    chk_move(0, 32'h8000, 17'h100, "R1 R5 first chunk");
    chk_move(1, 32'h9000, 17'h080, "R1 R5 second chunk");
    chk("R6 count", r_cnt, 32'h180);
    chk("R6 underrun", r_und, 0);
    chk("R3 fetches", rd_n - f0, 2);

    pulse_load(0);
    run(32'h40, "R5 partial");
    chk_move(0, 32'h8000, 17'h40, "R5 partial chunk");
    run(32'h100, "R4 carry");
    chk("R4 fetches", rd_n - f0, 1);
    chk_move(0, 32'h8040, 17'h0C0, "R4 resume segment");
    chk_move(1, 32'h9000, 17'h040, "R4 next descriptor");
    chk("R4 count", r_cnt, 32'h100);
    chk("R4 underrun", r_und, 0);

    pulse_load(0);
    run(32'h200, "R7");
    chk("R7 underrun", r_und, 1);
    chk("R7 count", r_cnt, 32'h180);
    chk("R3 no fetch past last", rd_n - f0, 2);

    pulse_load(0);
    run(32'h40, "R9 setup");
    pulse_load(1);
    run(32'h100, "R9");
    chk_move(0, 32'h8040, 17'h0C0, "R9 segment kept");
    chk_move(1, 32'h8000, 17'h040, "R9 pointer rewound");
    chk("R9 count", r_cnt, 32'h100);

    tbl[0] = {32'h7FFF_0011, 32'h0000_A000};
    tbl[1] = {32'h8000_0000, 32'h0002_0000};
    pulse_load(0);
    run(32'h10010, "R2");
    chk_move(0, 32'hA000, 17'h00010, "R2 masked count");
    chk_move(1, 32'h20000, 17'h10000, "R2 zero means 65536");
    chk("R2 count", r_cnt, 32'h10010);
    chk("R2 underrun", r_und, 0);

    for (int i = 0; i < 64; i++) tbl[i] = {32'h0000_0003, TBASE + 32'(i * 8)};
    pulse_load(0);
    run(32'h10000, "R8");
    chk("R8 fetches", rd_n - f0, 512);
    chk("R8 moves", mv_n - m0, 512);
    chk("R8 underrun", r_und, 1);
    chk("R8 count", r_cnt, 1024);
    chk_move(0, TBASE, 17'd2, "R1 R2 fill chunk");

    tbl[0] = {32'h0000_0000, 32'h0000_C000};
    tbl[1] = {32'h8000_0000, 32'h0000_D000};
    pulse_load(0);
    run(32'h20000, "R10");
    chk("R10 moves", mv_n - m0, 1);
    chk("R10 err", r_err, 1);
    chk("R10 underrun", r_und, 0);
    chk("R10 count", r_cnt, LIMIT);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule